// File: doc/BRIEF.md
# I2C Slave Controller with Configurable Bit Order and SCL Filter

This block is a bus slave for a two-wire serial bus built from open-drain clock and data lines. It samples the SCL and SDA inputs with the system clock and pulls SDA low through a single output-enable signal. It detects START and STOP conditions and compares the first byte of each transfer against a programmable 7-bit own address or the general call address. In a write transfer, each data byte is acknowledged, stored in a holding register and flagged with a sticky receive event. In a read transfer, the slave shifts out a byte that has been preloaded into a transmit register.

A small register-write port configures the block and clears its event flag. The 8-bit mode register has the following controls:
- the order in which data bits travel on the wire;
- whether the general call address is acknowledged;
- whether SCL passes through a digital spike filter before its edges are detected;
- a global enable.

Clock stretching, arbitration between masters and 10-bit addressing are not provided.

Top module: `i2c_slave_ctrl`

## Requirements
- R1: After reset `mode_q`, `rx_data`, `rx_event` and `sda_oe` are all zero. A write with `wr_sel`=0 loads the mode register, which reads back on `mode_q`. Bits `wr_data[7:6]` are reserved and always read as zero. The mode fields are: reverse data at [5], general-call disable at [4], SCL filter at [3], a stored prescaler at [2:1] and enable at [0].
- R2: START is SDA falling while SCL is high, and it begins a new address phase even in the middle of a transfer (repeated START). STOP is SDA rising while SCL is high; it returns the block to idle with SDA released and discards any partial byte.
- R3: The address byte is always received msb first, with the 7-bit address in its upper bits and the R/W bit last (1 = read). The own address is loaded by `wr_sel`=1 from `wr_data[6:0]`. On a match, SDA is held low for the whole ninth clock. On a mismatch, SDA stays released and the rest of the transfer is ignored until the next START or STOP.
- R4: Address 0 with R/W=0 is the general call. With general-call disable at 0 it is acknowledged and its data bytes are received. With the disable at 1 it gets no acknowledge and raises no receive event.
- R5: In an addressed write, every data byte is acknowledged on its ninth clock, is copied to `rx_data` and sets `rx_event`.
- R6: With reverse data at 0, data bytes move msb first in both directions. With it at 1 they move lsb first, and the first wire bit becomes bit 0.
- R7: In an addressed read, the byte loaded by `wr_sel`=2 is driven out, and the same byte is sent again after each master acknowledge. After a master NACK, SDA stays released until the next START or STOP.
- R8: With the filter bit at 1, SCL is used only after three equal consecutive samples, so a one-clock glitch adds no edge. With the filter bit at 0, the synchronized raw SCL is used and a glitch produces an extra bit sample.
- R9: With enable at 0, the block keeps SDA released, acknowledges nothing and raises no receive event.
- R10: `rx_event` stays set until a write with `wr_sel`=3 and `wr_data[0]`=1 clears it. The same write with `wr_data[0]`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | input | 1 | Register-write strobe |
| wr_sel | input | 2 | Target: 0 mode, 1 own address, 2 transmit byte, 3 event clear |
| wr_data | input | 8 | Write data |
| mode_q | output | 8 | Current mode register |
| rx_data | output | 8 | Last received data byte |
| rx_event | output | 1 | Sticky receive event flag |

## Verification
Each line input passes through two synchronizer flops, an edge register and the state register; the filter adds four more flops. As a result:
- the acknowledge and transmit bits appear on `sda_oe` within about eight clocks of an SCL edge;
- `rx_data` and `rx_event` update about the same number of clocks after the eighth rising SCL edge of a byte.

The bench holds each SCL phase for twenty clocks and changes SDA ten clocks into the low phase. It samples the wire ten clocks into the high phase and reads registers only after a STOP, well beyond every one of these latencies.

// File: rtl/i2cs_pkg.sv
// Shared definitions for the I2C slave controller.
// Assumes: bytes are 8 bits wide and addresses are 7 bits wide.
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // Mode register layout; the bit positions are visible to software.
    typedef struct packed {
        logic [1:0] rsvd;   // always zero
        logic       revd;   // 1: lsb first on the wire
        logic       gcd;    // 1: ignore the general call
        logic       flt;    // 1: filter SCL
        logic [1:0] pdiv;   // stored prescaler field
        logic       en;     // block enable
    } mode_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK_W,
        ST_AACK,
        ST_RX,
        ST_RACK_W,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } slv_st_e;

endpackage

// File: rtl/i2cs_line_cond.sv
// Line conditioning: synchronizes SCL and SDA to clk. It also builds a
// consecutive-equal filter on SCL and picks the filtered or raw SCL.
// Assumes: SYNC_STAGES >= 2 and FILT_LEN >= 2. Idle lines are high.
module i2cs_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flt_en,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_o,
    output logic sda_o
);
    localparam int SM = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic [FILT_LEN-1:0]    win;
    logic                   filt;

    // Synchronizer chains; reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_raw};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_raw};
        end
    end

    // Sample window of the synchronized SCL.
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '1;
        else        win <= {win[FILT_LEN-2:0], scl_sync[SM]};
    end

    // Filtered SCL changes only once the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)        filt <= 1'b1;
        else if (&win)     filt <= 1'b1;
        else if (~|win)    filt <= 1'b0;
    end

    assign scl_o = flt_en ? filt : scl_sync[SM];
    assign sda_o = sda_sync[SM];

    // R8: a mixed window never moves the filtered level.
    a_r8_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((|win) && !(&win)) |=> $stable(filt));

endmodule

// File: rtl/i2cs_bus_events.sv
// Bus event detector: turns the conditioned SCL and SDA into one-cycle
// SCL edge, START and STOP pulses.
// Assumes: inputs are already synchronous to clk.
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_lvl
);
    logic scl_q;
    logic sda_q;

    // Previous-cycle line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = scl_c && !scl_q;
        scl_fall  = !scl_c && scl_q;
        start_evt = scl_c && scl_q && sda_q && !sda_c;
        stop_evt  = scl_c && scl_q && !sda_q && sda_c;
        sda_lvl   = sda_c;
    end

endmodule

// File: rtl/i2cs_slave_fsm.sv
// Slave protocol engine: address match, acknowledge, data receive and
// data transmit, stepped by the SCL edge and START/STOP pulses.
// Assumes: BITS == AW + 1. The address byte always travels msb first.
module i2cs_slave_fsm
    import i2cs_pkg::*;
#(
    parameter int BITS = 8,
    parameter int AW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            revd,
    input  logic            gcd,
    input  logic [AW-1:0]   own_addr,
    input  logic [BITS-1:0] tx_byte,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_evt,
    input  logic            stop_evt,
    input  logic            sda_in,
    output logic            sda_oe,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_strobe
);
    localparam int            CW   = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    slv_st_e         st;
    logic [BITS-1:0] sh;
    logic [BITS-1:0] txsh;
    logic [CW-1:0]   cnt;
    logic            rw;
    logic            mack;

    logic [BITS-1:0] sh_msb;
    logic [BITS-1:0] sh_lsb;
    logic [AW-1:0]   addr_nx;
    logic            rw_nx;
    logic            hit;
    logic [CW-1:0]   bit_idx;

    // Next shift values and the address compare.
    always_comb begin
        sh_msb  = {sh[BITS-2:0], sda_in};
        sh_lsb  = {sda_in, sh[BITS-1:1]};
        addr_nx = sh_msb[BITS-1:1];
        rw_nx   = sh_msb[0];
        hit     = (addr_nx == own_addr) ||
                  ((addr_nx == '0) && !rw_nx && !gcd);
        bit_idx = revd ? cnt : (LAST - cnt);
    end

    // Protocol state, shift registers and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            sh        <= '0;
            txsh      <= '0;
            cnt       <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            rx_byte   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (!en) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else if (start_evt) begin
                st  <= ST_ADDR;
                cnt <= '0;
            end else if (stop_evt) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else begin
                case (st)
                    ST_ADDR: if (scl_rise) begin
                        sh  <= sh_msb;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt <= '0;
                            rw  <= rw_nx;
                            st  <= hit ? ST_AACK_W : ST_WAIT;
                        end
                    end
                    ST_AACK_W: if (scl_fall) st <= ST_AACK;
                    ST_AACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            txsh <= tx_byte;
                            st   <= ST_TX;
                        end else begin
                            st <= ST_RX;
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        sh  <= revd ? sh_lsb : sh_msb;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            rx_byte   <= revd ? sh_lsb : sh_msb;
                            rx_strobe <= 1'b1;
                            st        <= ST_RACK_W;
                        end
                    end
                    ST_RACK_W: if (scl_fall) st <= ST_RACK;
                    ST_RACK: if (scl_fall) begin
                        cnt <= '0;
                        st  <= ST_RX;
                    end
                    ST_TX: if (scl_fall) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt <= '0;
                            st  <= ST_TACK;
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) mack <= !sda_in;
                        if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                txsh <= tx_byte;
                                st   <= ST_TX;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA pull-down: acknowledge windows and transmit zeros.
    always_comb begin
        sda_oe = 1'b0;
        if (en) begin
            case (st)
                ST_AACK, ST_RACK: sda_oe = 1'b1;
                ST_TX:            sda_oe = !txsh[bit_idx];
                default:          sda_oe = 1'b0;
            endcase
        end
    end

    // R2: START always opens a fresh address phase.
    a_r2_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_evt) |=> (st == ST_ADDR));

    // R5: a byte strobe only leaves the receive state.
    a_r5_strobe_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> ($past(st) == ST_RX));

    // R9: a disabled block parks in idle.
    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_IDLE));

endmodule

// File: rtl/i2c_slave_ctrl.sv
// Top of the I2C slave controller. It holds the configuration registers,
// the receive holding register and the sticky event, and wires the
// conditioning, event and protocol stages together.
// Assumes: SCL/SDA inputs are the wired-AND bus levels.
module i2c_slave_ctrl
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_event
);
    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_OWN  = 2'd1;
    localparam logic [1:0] SEL_TX   = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

    mode_t             mode_r;
    logic [ADDR_W-1:0] own_r;
    logic [BYTE_W-1:0] tx_r;
    logic              scl_c, sda_c;
    logic              scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_strobe;
    logic              clr_req;

    assign clr_req = wr_en && (wr_sel == SEL_CLR) && wr_data[0];

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            own_r  <= '0;
            tx_r   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MODE: mode_r <= mode_t'({2'b00, wr_data[5:0]});
                SEL_OWN:  own_r  <= wr_data[ADDR_W-1:0];
                SEL_TX:   tx_r   <= wr_data;
                default:  ;
            endcase
        end
    end

    // Receive holding register and sticky event; a new byte wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_event <= 1'b0;
        end else begin
            if (rx_strobe) rx_data <= rx_byte;
            if (rx_strobe)    rx_event <= 1'b1;
            else if (clr_req) rx_event <= 1'b0;
        end
    end

    assign mode_q = mode_r;

    i2cs_line_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) cond_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flt_en (mode_r.flt),
        .scl_raw(scl_i),
        .sda_raw(sda_i),
        .scl_o  (scl_c),
        .sda_o  (sda_c)
    );

    i2cs_bus_events evt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_c    (scl_c),
        .sda_c    (sda_c),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_lvl  (sda_lvl)
    );

    i2cs_slave_fsm #(
        .BITS(BYTE_W),
        .AW  (ADDR_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_r.en),
        .revd     (mode_r.revd),
        .gcd      (mode_r.gcd),
        .own_addr (own_r),
        .tx_byte  (tx_r),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_in   (sda_lvl),
        .sda_oe   (sda_oe),
        .rx_byte  (rx_byte),
        .rx_strobe(rx_strobe)
    );

    // R10: the event flag only drops on an explicit clear.
    a_r10_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_event && !clr_req) |=> rx_event);

    // R2: after STOP the data line is released.
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

endmodule

// File: tb/i2c_slave_ctrl_tb_top.sv
// Self-checking bench: a master model drives SCL/SDA, with a vector table
// of write transfers followed by directed tests.
module i2c_slave_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int NV         = 7;

    // {mode, addr byte, data byte, exp ack, exp rx, exp event}
    localparam logic [33:0] VECS [0:NV-1] = '{
        {8'h01, 8'h54, 8'hA5, 1'b1, 8'hA5, 1'b1},
        {8'h01, 8'h56, 8'h3C, 1'b0, 8'h00, 1'b0},
        {8'h21, 8'h54, 8'h80, 1'b1, 8'h01, 1'b1},
        {8'h01, 8'h00, 8'h5A, 1'b1, 8'h5A, 1'b1},
        {8'h11, 8'h00, 8'h77, 1'b0, 8'h00, 1'b0},
        {8'h21, 8'h54, 8'h35, 1'b1, 8'hAC, 1'b1},
        {8'h09, 8'h54, 8'hC3, 1'b1, 8'hC3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       sda_oe;
    logic [7:0] mode_q, rx_data;
    logic       rx_event;
    logic       sda_line;
    int         total = 0;
    int         fails = 0;
    bit         done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .rx_data (rx_data),
        .rx_event(rx_event)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(Q);
        if (glitch) begin
            m_scl = 1'b0; wq(1);
            m_scl = 1'b1;
        end
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int gbit, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i], i == gbit);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(!give_ack, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic       b;
        logic [7:0] v;

        wq(5);
        rst_n = 1'b1;
        wq(2);
        // R1: reset state
        check("R1 mode reset", mode_q, 8'h00);
        check("R1 rx_data reset", rx_data, 8'h00);
        check("R1 rx_event reset", {7'd0, rx_event}, 8'h00);
        check("R1 sda_oe reset", {7'd0, sda_oe}, 8'h00);
        // R1: reserved bits read as zero
        reg_wr(2'd0, 8'hFF);
        check("R1 reserved bits", mode_q, 8'h3F);
        reg_wr(2'd1, 8'h2A);

        // Vector table of write transfers (R3 R4 R5 R6 R8)
        for (int k = 0; k < NV; k++) begin
            reg_wr(2'd0, VECS[k][33:26]);
            reg_wr(2'd3, 8'h01);
            bus_start();
            send_byte(VECS[k][25:18], -1, ack);
            check($sformatf("R3/R4 vec%0d addr ack", k), {7'd0, ack}, {7'd0, VECS[k][9]});
            send_byte(VECS[k][17:10], -1, ack);
            check($sformatf("R5 vec%0d data ack", k), {7'd0, ack}, {7'd0, VECS[k][9]});
            bus_stop();
            check($sformatf("R5 vec%0d event", k), {7'd0, rx_event}, {7'd0, VECS[k][0]});
            if (VECS[k][0])
                check($sformatf("R5/R6 vec%0d rx_data", k), rx_data, VECS[k][8:1]);
        end

        // R10: event sticky, clear with bit0=1 only
        wq(50);
        check("R10 event held", {7'd0, rx_event}, 8'h01);
        reg_wr(2'd3, 8'h00);
        check("R10 clear with bit0=0 ignored", {7'd0, rx_event}, 8'h01);
        reg_wr(2'd3, 8'h01);
        check("R10 cleared", {7'd0, rx_event}, 8'h00);

        // R2: repeated START after a mismatched address
        reg_wr(2'd0, 8'h01);
        bus_start();
        send_byte(8'h56, -1, ack);
        check("R2 mismatch no ack", {7'd0, ack}, 8'h00);
        bus_rstart();
        send_byte(8'h54, -1, ack);
        check("R2 repeated start ack", {7'd0, ack}, 8'h01);
        send_byte(8'h66, -1, ack);
        bus_stop();
        check("R2 repeated start rx", rx_data, 8'h66);

        // R2: STOP mid-byte discards the partial byte
        reg_wr(2'd3, 8'h01);
        bus_start();
        send_byte(8'h54, -1, ack);
        put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0);
        bus_stop();
        check("R2 stop mid-byte no event", {7'd0, rx_event}, 8'h00);
        check("R2 stop releases sda", {7'd0, sda_oe}, 8'h00);
        bus_start();
        send_byte(8'h54, -1, ack);
        send_byte(8'h11, -1, ack);
        bus_stop();
        check("R2 transfer after stop", rx_data, 8'h11);

        // R7: read, reload after ACK, release after NACK
        reg_wr(2'd2, 8'h9C);
        bus_start();
        send_byte(8'h55, -1, ack);
        check("R7 read addr ack", {7'd0, ack}, 8'h01);
        recv_byte(v, 1'b1);
        check("R7 first read byte", v, 8'h9C);
        recv_byte(v, 1'b0);
        check("R7 reload after ack", v, 8'h9C);
        get_bit(b);
        check("R7 released after nack", {7'd0, b}, 8'h01);
        bus_stop();

        // R6: read with lsb-first order
        reg_wr(2'd0, 8'h21);
        bus_start();
        send_byte(8'h55, -1, ack);
        recv_byte(v, 1'b0);
        check("R6 lsb-first transmit", v, 8'h39);
        bus_stop();

        // R8: glitch rejected with filter on
        reg_wr(2'd0, 8'h09);
        reg_wr(2'd3, 8'h01);
        bus_start();
        send_byte(8'h54, -1, ack);
        send_byte(8'hA5, 7, ack);
        check("R8 filtered ack", {7'd0, ack}, 8'h01);
        bus_stop();
        check("R8 filtered rx", rx_data, 8'hA5);

        // R8: glitch seen as an extra bit with filter off
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd3, 8'h01);
        bus_start();
        send_byte(8'h54, -1, ack);
        send_byte(8'hA5, 7, ack);
        bus_stop();
        check("R8 raw glitch rx", rx_data, 8'hD2);
        check("R8 raw glitch event", {7'd0, rx_event}, 8'h01);

        // R9: disabled block ignores the bus
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd3, 8'h01);
        bus_start();
        send_byte(8'h54, -1, ack);
        check("R9 no ack when off", {7'd0, ack}, 8'h00);
        send_byte(8'h42, -1, ack);
        bus_stop();
        check("R9 no event when off", {7'd0, rx_event}, 8'h00);
        check("R9 sda released", {7'd0, sda_oe}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule